// File: doc/BRIEF.md
# Periodic Rate-Generator Interval Timer

This block produces the periodic interrupt tick that an operating system uses for its clock and for kernel profiling. Software loads a 16-bit reload value N one byte at a time, low byte first. The counter then steps down by one on each pulse of a clock-enable input, which runs at the tick rate, for example 1.25 MHz (0.8 µs) or 312.5 kHz (3.2 µs). The counter refills itself from the reload register, so the expiry output rises once every N ticks. For example, 12500 ticks at 0.8 µs gives a 10 ms period, and 31250 ticks at 3.2 µs gives a 100 ms period.

The sequencing follows a rate generator. The expiry output is high while the count holds 1. The tick that leaves 1 loads N again. That same tick raises a zero-reached flag for one tick period. A downstream interrupt latch uses this flag as its permission to clear. The live count is always visible on a read port, and reading it does not affect counting.

Top module: `tick_rate_timer`

## Requirements
- R1: After reset the timer is idle. The count reads 0, and the expiry and zero-reached outputs are low. Tick pulses have no effect until a reload value has been accepted.
- R2: A write with `wr_hi`=0 stores the low byte. A following write with `wr_hi`=1 completes the value {high, low}. If the timer is idle, the count reads that value on the clock edge of the high-byte write, and the first tick after the write decrements it.
- R3: While the timer is armed, each clock with `tick_en` high lowers the count by exactly one, except when the count is 1. A clock without `tick_en` leaves the count unchanged. The count port shows the live value at all times.
- R4: The expiry output is high exactly while the armed count equals 1. A tick at count 1 loads the reload value, so expiry rises once every N ticks.
- R5: The zero-reached output goes high on the tick that performs the reload. It goes low again on the following tick.
- R6: A new reload value accepted while the timer is counting does not change the current count. It is used from the next reload onward.
- R7: A high-byte write that is not preceded by a low-byte write since the last high-byte write is ignored.
- R8: A completed value below 2 is rejected. An idle timer stays idle, and an armed timer keeps its previous reload value.
- R9: The full 16-bit range is usable. With reload 65535 the count starts at 65535 and steps to 65534.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe for the reload value |
| wr_hi | input | 1 | Byte select: 0 = low byte, 1 = high byte (completes the value) |
| wr_data | input | 8 | Byte written |
| tick_en | input | 1 | Clock-enable pulse at the tick rate |
| count_o | output | 16 | Live counter value |
| expire_o | output | 1 | Expiry, high while the count is 1 |
| zero_o | output | 1 | Zero-reached flag, high for the tick after expiry |

## Verification
The timer is driven with short reload values (5 and 3). These show the exact order of count, expiry and zero-reached around a reload, and they separate a period of N ticks from a period of N+1. Gaps without ticks between ticks show that counting follows only the enable. A rewrite in the middle of a period, a lone high-byte write and a value of 1 separate "applies at the next reload" from "applies at once" and from "accepted in error". A long run at 12500 and a load of 65535 confirm that the full period length and the full range work across the byte boundary.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    typedef enum logic {
        SEL_LO = 1'b0,
        SEL_HI = 1'b1
    } byte_sel_e;

    // Smallest reload value that still gives a distinct expiry tick
    parameter int unsigned RELOAD_FLOOR = 2;

endpackage

// File: rtl/tmr_byte_loader.sv
module tmr_byte_loader
    import tick_timer_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_hi,
    input  logic [BYTE_W-1:0]     wr_data,
    output logic                  commit_o,
    output logic [2*BYTE_W-1:0]   value_o
);

    typedef struct packed {
        logic              pend;
        logic [BYTE_W-1:0] lo;
    } ld_state_t;

    ld_state_t ld_d, ld_q;

    always_comb begin
        ld_d     = ld_q;
        commit_o = 1'b0;
        value_o  = {wr_data, ld_q.lo};
        if (wr_en) begin
            if (wr_hi == SEL_HI) begin
                commit_o = ld_q.pend;
                ld_d.pend = 1'b0;
            end else begin
                ld_d.lo   = wr_data;
                ld_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q <= '0;
        end else begin
            ld_q <= ld_d;
        end
    end

endmodule

// File: rtl/tmr_rate_core.sv
module tmr_rate_core
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned MIN_RLD   = RELOAD_FLOOR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load_req,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o,
    output logic             zero_o,
    output logic             armed_o
);

    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_RLD);

    typedef struct packed {
        logic             armed;
        logic             zero;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        accept;

    always_comb begin
        st_d   = st_q;
        accept = load_req && (load_val >= FLOOR);
        if (!st_q.armed) begin
            if (accept) begin
                st_d.armed = 1'b1;
                st_d.cnt   = load_val;
                st_d.rld   = load_val;
            end
        end else begin
            if (accept) begin
                st_d.rld = load_val;
            end
            if (tick_en) begin
                if (st_q.cnt == ONE) begin
                    st_d.cnt  = st_q.rld;
                    st_d.zero = 1'b1;
                end else begin
                    st_d.cnt  = st_q.cnt - ONE;
                    st_d.zero = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o  = st_q.cnt;
    assign expire_o = st_q.armed && (st_q.cnt == ONE);
    assign zero_o   = st_q.zero;
    assign armed_o  = st_q.armed;

endmodule

// File: rtl/tick_rate_timer.sv
module tick_rate_timer
    import tick_timer_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_hi,
    input  logic [BYTE_W-1:0]     wr_data,
    input  logic                  tick_en,
    output logic [2*BYTE_W-1:0]   count_o,
    output logic                  expire_o,
    output logic                  zero_o
);

    localparam int unsigned CNT_W = 2 * BYTE_W;

    logic             ld_commit;
    logic [CNT_W-1:0] ld_value;
    logic             core_armed;

    tmr_byte_loader #(.BYTE_W(BYTE_W)) u_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_hi    (wr_hi),
        .wr_data  (wr_data),
        .commit_o (ld_commit),
        .value_o  (ld_value)
    );

    tmr_rate_core #(.CNT_W(CNT_W), .MIN_RLD(RELOAD_FLOOR)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .load_req (ld_commit),
        .load_val (ld_value),
        .count_o  (count_o),
        .expire_o (expire_o),
        .zero_o   (zero_o),
        .armed_o  (core_armed)
    );

endmodule

// File: rtl/tick_rate_timer_chk.sv
module tick_rate_timer_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             armed,
    input logic [CNT_W-1:0] count_o,
    input logic             expire_o,
    input logic             zero_o
);

    // R1: idle state shows nothing
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (count_o == '0) && !expire_o && !zero_o);

    // R3: one step down per tick above 1
    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        armed && tick_en && (count_o > CNT_W'(1)) |=> count_o == $past(count_o) - CNT_W'(1));

    // R3: no tick, no change
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !tick_en |=> $stable(count_o));

    // R4: tick at expiry reloads to a legal value
    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o && tick_en |=> !expire_o && (count_o >= CNT_W'(2)));

    // R5: zero-reached follows the expiry tick
    assert_zero_after_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o && tick_en |=> zero_o);

    // R5: zero-reached only rises from an expiry tick
    assert_zero_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_o) |-> $past(expire_o && tick_en));

endmodule

bind tick_rate_timer tick_rate_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .armed    (core_armed),
    .count_o  (count_o),
    .expire_o (expire_o),
    .zero_o   (zero_o)
);

// File: tb/tick_rate_timer_bench.sv
module tick_rate_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_hi = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        tick_en = 1'b0;
    logic [15:0] count_o;
    logic        expire_o;
    logic        zero_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    tick_rate_timer u_tick_rate_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_hi    (wr_hi),
        .wr_data  (wr_data),
        .tick_en  (tick_en),
        .count_o  (count_o),
        .expire_o (expire_o),
        .zero_o   (zero_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_byte(input logic hi, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_hi = hi; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_value(input logic [15:0] v);
        wr_byte(1'b0, v[7:0]);
        wr_byte(1'b1, v[15:8]);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ticks until expiry is seen, bounded
    task automatic ticks_to_expire(output int n);
        n = 0;
        while (!expire_o && n < 70000) begin
            tick(1);
            n++;
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 count after reset", count_o, 0);
        check("R1 expiry after reset", expire_o, 0);
        check("R1 zero after reset", zero_o, 0);
        tick(3);
        check("R1 ticks ignored while idle", count_o, 0);
    endtask

    task automatic t_basic();
        int n;
        wr_value(16'd5);
        check("R2 armed count", count_o, 5);
        tick(1);
        check("R3 first decrement", count_o, 4);
        idle_cycles(5);
        check("R3 hold without tick", count_o, 4);
        tick(3);
        check("R4 count at 1", count_o, 1);
        check("R4 expiry at 1", expire_o, 1);
        check("R5 zero low before reload", zero_o, 0);
        tick(1);
        check("R4 reload value", count_o, 5);
        check("R4 expiry drops", expire_o, 0);
        check("R5 zero after reload tick", zero_o, 1);
        idle_cycles(3);
        check("R5 zero holds between ticks", zero_o, 1);
        tick(1);
        check("R5 zero clears next tick", zero_o, 0);
        check("R3 decrement after reload", count_o, 4);
        tick(3);
        tick(1);
        ticks_to_expire(n);
        check("R4 period of N ticks", n + 1, 5);
    endtask

    task automatic t_rewrite();
        // count is 1 here; step to 4
        tick(2);
        check("R6 count before rewrite", count_o, 4);
        wr_value(16'd3);
        check("R6 count undisturbed", count_o, 4);
        tick(3);
        check("R6 old period completes", expire_o, 1);
        tick(1);
        check("R6 new value at next reload", count_o, 3);
    endtask

    task automatic t_orphan_hi();
        wr_byte(1'b1, 8'h01);
        tick(2);
        check("R7 expiry before reload", expire_o, 1);
        tick(1);
        check("R7 lone high byte ignored", count_o, 3);
    endtask

    task automatic t_reject();
        wr_value(16'd1);
        tick(2);
        tick(1);
        check("R8 reload kept after value 1", count_o, 3);
        do_reset();
        wr_value(16'd0);
        check("R8 idle after value 0", count_o, 0);
        tick(2);
        check("R8 still idle", count_o, 0);
        check("R8 no expiry", expire_o, 0);
    endtask

    task automatic t_long();
        int n;
        do_reset();
        wr_value(16'd12500);
        check("R2 armed 12500", count_o, 12500);
        ticks_to_expire(n);
        check("R4 first expiry after N-1 ticks", n, 12499);
        tick(1);
        ticks_to_expire(n);
        check("R4 10 ms period in ticks", n + 1, 12500);
    endtask

    task automatic t_max();
        do_reset();
        wr_value(16'hFFFF);
        check("R9 full-range load", count_o, 65535);
        tick(1);
        check("R9 full-range step", count_o, 65534);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_rewrite();
        t_orphan_hi();
        t_reject();
        t_long();
        t_max();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule